// File: doc/BRIEF.md
# Serial Debug Shift-Register Port

This block is a chip-level serial debug port. An external debugger drives a handful of control lines and one serial data line. The block keeps a 16-bit shift register that the debugger fills and drains one bit at a time. On an execute request, the block decodes the register contents as a command that reads or writes one of eight 12-bit internal debug registers. Each write is also announced on a parallel write bus for the rest of the chip.

The block models a two-phase clock on one system clock. An internal toggle marks alternate cycles as phase A and phase B, and the toggle is visible on `phase_b_o`.

- The debugger changes its controls during phase A.
- The block latches them at the end of phase B.
- The latched request acts at the end of the following phase A.
- The serial output changes only at the start of a phase A and then holds through the next phase B.

Top module: `sdbg_port`

## Requirements
- R1: Controls are latched at the end of a phase-B cycle. The latched request changes the shift register only at the end of the next phase-A cycle, so the shift register never changes across a phase-B-to-phase-A edge.
- R2: `dbg_dout_o` takes the shift register's bit 0 at the end of each phase-B cycle and is stable through every phase-B cycle. An operation requested in phase pair k appears on `dbg_dout_o` during pair k+2.
- R3: With hold high, select-low low, shift high and execute low, the register moves right by exactly one bit per phase pair. The latched data-in bit enters at bit 15, and bit 0 leaves.
- R4: While `dbg_nsel_i` is high, shift and execute requests have no effect on the shift register or the debug registers.
- R5: While `dbg_hold_i` is low, shift and execute requests have no effect.
- R6: The command fields are: bit 15 selects write (1) or read (0), bits 14:12 give the register index, and bits 11:0 hold the write data. An honoured execute with bit 15 = 0 loads the indexed register into bits 11:0 and keeps bits 15:12 unchanged.
- R7: An honoured execute with bit 15 = 1 stores bits 11:0 into the indexed register and leaves the shift register unchanged. It raises `reg_wr_o` for exactly one cycle, in the phase-B cycle after the action, carrying the index and data on `reg_idx_o`/`reg_wdata_o`.
- R8: When shift and execute are both honoured in the same pair, only the execute takes place.
- R9: A latched `dbg_rst_i` clears the shift register and all eight debug registers, whatever the state of hold, select-low, shift and execute.
- R10: While `rst_n` is low, all state is cleared. After release the block starts in phase A with `dbg_dout_o` = 0 and `reg_wr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; alternate cycles are phase A and phase B |
| rst_n | input | 1 | Active-low chip reset |
| dbg_rst_i | input | 1 | Debug-side reset request |
| dbg_hold_i | input | 1 | Hold qualifier; must be high for shift or execute to be honoured |
| dbg_shift_i | input | 1 | Shift request |
| dbg_exec_i | input | 1 | Execute request |
| dbg_nsel_i | input | 1 | Select-low gate; when high, shift and execute are blocked |
| dbg_din_i | input | 1 | Serial data in |
| dbg_dout_o | output | 1 | Serial data out |
| phase_b_o | output | 1 | High during phase-B cycles |
| reg_wr_o | output | 1 | One-cycle debug-register write strobe |
| reg_idx_o | output | 3 | Index of the register written |
| reg_wdata_o | output | 12 | Data written |

## Verification
The hardest state to reach from the ports is a read whose result depends on earlier writes after a debug reset. This matters most when shift and execute arrive together, because the only way to see the shift register is to drain it serially two phase pairs later. The bench therefore drives an unbroken stream of phase pairs in which every operation is followed by a full 16-bit shift-out. A running model predicts every output bit and every strobe at its exact phase.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;
    localparam int SR_W  = 16;
    localparam int IDX_W = 3;
    localparam int DAT_W = 12;
    localparam int NREG  = 1 << IDX_W;
    localparam int WR_BIT = SR_W - 1;
    localparam int IDX_HI = SR_W - 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_EXEC  = 2'd2,
        OP_CLR   = 2'd3
    } op_e;

    typedef struct packed {
        op_e  op;
        logic din;
    } req_t;

    typedef struct packed {
        logic [SR_W-1:0]  sreg;
        logic             dout;
        logic             wr;
        logic [IDX_W-1:0] widx;
        logic [DAT_W-1:0] wdat;
    } core_t;
endpackage

// File: rtl/sdbg_phase.sv
module sdbg_phase (
    input  logic clk,
    input  logic rst_n,
    output logic ph_b
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ph_d;
    end

    assign ph_b = ph_q;
endmodule

// File: rtl/sdbg_ctl.sv
module sdbg_ctl
    import sdbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_b,
    input  logic rst_in,
    input  logic hold,
    input  logic shift,
    input  logic exec,
    input  logic nsel,
    input  logic din,
    output req_t req
);
    req_t req_d, req_q;

    // Latch open in phase B; request lives through the next phase A only.
    always_comb begin
        req_d.op  = OP_NONE;
        req_d.din = 1'b0;
        if (ph_b) begin
            req_d.din = din;
            if (rst_in)
                req_d.op = OP_CLR;
            else if (hold && !nsel) begin
                if (exec)       req_d.op = OP_EXEC;
                else if (shift) req_d.op = OP_SHIFT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '{op: OP_NONE, din: 1'b0};
        else        req_q <= req_d;
    end

    assign req = req_q;
endmodule

// File: rtl/sdbg_bank.sv
module sdbg_bank
    import sdbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DAT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DAT_W-1:0] rdata
);
    logic [DAT_W-1:0] bank_d [NREG];
    logic [DAT_W-1:0] bank_q [NREG];

    always_comb begin
        bank_d = bank_q;
        if (clr) begin
            for (int i = 0; i < NREG; i++) bank_d[i] = '0;
        end else if (we) begin
            bank_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata = bank_q[ridx];
endmodule

// File: rtl/sdbg_port.sv
module sdbg_port
    import sdbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_rst_i,
    input  logic             dbg_hold_i,
    input  logic             dbg_shift_i,
    input  logic             dbg_exec_i,
    input  logic             dbg_nsel_i,
    input  logic             dbg_din_i,
    output logic             dbg_dout_o,
    output logic             phase_b_o,
    output logic             reg_wr_o,
    output logic [IDX_W-1:0] reg_idx_o,
    output logic [DAT_W-1:0] reg_wdata_o
);
    logic             ph_b;
    req_t             req;
    core_t            s_d, s_q;
    logic             bank_we, bank_clr;
    logic [IDX_W-1:0] cmd_idx;
    logic [DAT_W-1:0] rd_val;

    sdbg_phase u_phase (.clk(clk), .rst_n(rst_n), .ph_b(ph_b));

    sdbg_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .ph_b(ph_b),
        .rst_in(dbg_rst_i), .hold(dbg_hold_i), .shift(dbg_shift_i),
        .exec(dbg_exec_i), .nsel(dbg_nsel_i), .din(dbg_din_i),
        .req(req)
    );

    assign cmd_idx  = s_q.sreg[IDX_HI -: IDX_W];
    assign bank_clr = (req.op == OP_CLR);
    assign bank_we  = (req.op == OP_EXEC) && s_q.sreg[WR_BIT];

    sdbg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .clr(bank_clr), .we(bank_we),
        .widx(cmd_idx), .wdata(s_q.sreg[DAT_W-1:0]),
        .ridx(cmd_idx), .rdata(rd_val)
    );

    always_comb begin
        s_d    = s_q;
        s_d.wr = 1'b0;
        // Output register reloads as phase A begins.
        if (ph_b) s_d.dout = s_q.sreg[0];
        unique case (req.op)
            OP_CLR:   s_d.sreg = '0;
            OP_SHIFT: s_d.sreg = {req.din, s_q.sreg[SR_W-1:1]};
            OP_EXEC: begin
                if (s_q.sreg[WR_BIT]) begin
                    s_d.wr   = 1'b1;
                    s_d.widx = cmd_idx;
                    s_d.wdat = s_q.sreg[DAT_W-1:0];
                end else begin
                    s_d.sreg[DAT_W-1:0] = rd_val;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dbg_dout_o  = s_q.dout;
    assign phase_b_o   = ph_b;
    assign reg_wr_o    = s_q.wr;
    assign reg_idx_o   = s_q.widx;
    assign reg_wdata_o = s_q.wdat;
endmodule

// File: rtl/sdbg_port_chk.sv
module sdbg_port_chk
    import sdbg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ph_b,
    input logic            dout,
    input logic            wr,
    input logic [SR_W-1:0] sreg,
    input logic            nsel,
    input logic            hold,
    input logic            drst
);
    AST_SREG_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_b |-> $stable(sreg)); // R1
    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_b |-> $stable(dout)); // R2
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr); // R7
    AST_WR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> ph_b); // R7
    AST_NSEL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_b && nsel && !drst) |=> ##1 $stable(sreg)); // R4
    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_b && !hold && !drst) |=> ##1 $stable(sreg)); // R5
endmodule

bind sdbg_port sdbg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph_b(phase_b_o), .dout(dbg_dout_o),
    .wr(reg_wr_o), .sreg(s_q.sreg), .nsel(dbg_nsel_i),
    .hold(dbg_hold_i), .drst(dbg_rst_i)
);

// File: tb/sdbg_port_tb_top.sv
`timescale 1ns/1ps
module sdbg_port_tb_top;
    import sdbg_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, d_rst, d_hold, d_shift, d_exec, d_nsel, d_din;
    logic dout, ph_b, wr;
    logic [IDX_W-1:0] widx;
    logic [DAT_W-1:0] wdat;

    sdbg_port dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_rst_i(d_rst), .dbg_hold_i(d_hold),
        .dbg_shift_i(d_shift), .dbg_exec_i(d_exec), .dbg_nsel_i(d_nsel),
        .dbg_din_i(d_din), .dbg_dout_o(dout), .phase_b_o(ph_b),
        .reg_wr_o(wr), .reg_idx_o(widx), .reg_wdata_o(wdat)
    );

    typedef struct packed {
        logic             dout;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] dat;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    total = 0, bad = 0;
    bit    run = 0, done = 0;
    logic [SR_W-1:0]  msr = '0;
    logic [DAT_W-1:0] mbank [NREG];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one phase pair per call, controls changed in phase A.
    task automatic pair(input bit r, input bit h, input bit s, input bit e,
                        input bit ns, input bit d, input string tag);
        exp_t it;
        do @(negedge clk); while (ph_b);
        d_rst = r; d_hold = h; d_shift = s; d_exec = e; d_nsel = ns; d_din = d;
        it = '0;
        if (r) begin
            msr = '0;
            for (int i = 0; i < NREG; i++) mbank[i] = '0;
        end else if (h && !ns) begin
            if (e) begin
                if (msr[15]) begin
                    mbank[msr[14:12]] = msr[11:0];
                    it.wr = 1'b1; it.idx = msr[14:12]; it.dat = msr[11:0];
                end else begin
                    msr[11:0] = mbank[msr[14:12]];
                end
            end else if (s) begin
                msr = {d, msr[15:1]};
            end
        end
        it.dout = msr[0];
        q.push_back(it);
        tq.push_back(tag);
    endtask

    task automatic shift16(input logic [SR_W-1:0] v, input string tag);
        for (int i = 0; i < SR_W; i++) pair(0, 1, 1, 0, 0, v[i], tag);
    endtask

    // Monitor: in phase B, dout reflects call m-2, strobe reflects call m-1.
    initial begin
        forever begin
            @(negedge clk);
            if (run && ph_b && q.size() >= 3) begin
                chk({tq[0], " R2 dout"}, {31'd0, dout}, {31'd0, q[0].dout});
                chk({tq[1], " R7 strobe"}, {31'd0, wr}, {31'd0, q[1].wr});
                if (q[1].wr) begin
                    chk({tq[1], " R7 idx"}, {29'd0, widx}, {29'd0, q[1].idx});
                    chk({tq[1], " R7 data"}, {20'd0, wdat}, {20'd0, q[1].dat});
                end
                void'(q.pop_front());
                void'(tq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mbank[i] = '0;
        rst_n = 0; d_rst = 0; d_hold = 0; d_shift = 0; d_exec = 0; d_nsel = 0; d_din = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R10 dout", {31'd0, dout}, 32'd0);
        chk("R10 strobe", {31'd0, wr}, 32'd0);
        chk("R10 phase A", {31'd0, ph_b}, 32'd0);
        run = 1;
        pair(1, 0, 0, 0, 0, 0, "R9 clear");
        shift16(16'hDA5C, "R1/R3 load write");
        pair(0, 1, 0, 1, 0, 0, "R7 write idx5");
        shift16(16'hA3C1, "R3 load write");
        pair(0, 1, 0, 1, 0, 0, "R7 write idx2");
        shift16(16'h5000, "R3 load read");
        pair(0, 1, 0, 1, 0, 0, "R6 read idx5");
        shift16(16'h0F0F, "R6 drain");
        for (int i = 0; i < 3; i++) pair(0, 0, 1, 0, 0, 1, "R5 hold low shift");
        pair(0, 0, 0, 1, 0, 0, "R5 hold low exec");
        for (int i = 0; i < 3; i++) pair(0, 1, 1, 1, 1, 1, "R4 nsel high");
        shift16(16'h2123, "R4 drain");
        pair(0, 1, 1, 1, 0, 1, "R8 shift+exec");
        shift16(16'h8001, "R8 drain");
        pair(1, 0, 0, 0, 1, 0, "R9 clear gated");
        shift16(16'h5FFF, "R9 load read");
        pair(0, 1, 0, 1, 0, 0, "R9 read after clear");
        shift16(16'h0000, "R9 drain");
        for (int i = 0; i < 3; i++) pair(0, 0, 0, 0, 0, 0, "R2 flush");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule